// File: doc/BRIEF.md
# Fractional Compensated RTC Counter

This block keeps real time from a low-frequency clock that is meant to run at 32768 Hz but may run slightly fast or slow. The clock error is absorbed by a trimmable 24-bit increment expressed in units of 2^-38 s. The increment is added once per enabled clock cycle to a 32-bit subsecond fraction, in which 2^32 counts make one second. The carry out of the fraction advances a 32-bit seconds count. The increment is set to 2^38 divided by the measured clock frequency. Its reset value of 0x800000 gives exactly 1/32768 s per cycle.

The six least significant increment bits fall below the subsecond LSB. They are summed in a hidden 6-bit extension accumulator, and whenever that accumulator overflows it feeds a carry into the same cycle's subsecond addition. No fraction of an increment is ever lost. The active increment can only be read. A new value is staged through a 16-bit low write and an 8-bit high write, and a one-cycle commit strobe then copies it into the active increment. A count-enable input pauses all accumulation.

Top module: `rtc_frac_counter`

## Requirements
- R1: While `rst` is high at a clock edge, seconds, subsecond and the hidden accumulator clear to zero, and both the staged and the active increment take the value 0x800000.
- R2: On each clock edge with `countEn` high, the 70-bit quantity {seconds, subsecond, hidden accumulator} grows by the active increment. Increment bits [5:0] add to the 6-bit accumulator, bits [23:6] add to subsecond bits [17:0], and the accumulator overflow is carried into that same addition.
- R3: A carry out of bit 31 of the subsecond register adds one to the seconds register, and the subsecond register keeps only its low 32 bits.
- R4: With the default increment, seconds first reads 1 after exactly 32768 enabled cycles from reset, and it reads 2 after 65536.
- R5: For any increment `inc` held from reset, after N enabled cycles seconds equals floor(N*inc/2^38) and subsecond equals floor(N*inc/64) mod 2^32.
- R6: While `countEn` is low, seconds, subsecond and the hidden accumulator keep their values. Accumulated sub-LSB residue therefore survives a stall.
- R7: `wrLoEn` loads `wrLoData` into staged bits [15:0] and `wrHiEn` loads `wrHiData` into staged bits [23:16]. Neither write changes `activeInc` or the counting until a commit.
- R8: A `commit` pulse makes `activeInc` equal the staged value after that edge. A counting edge at the same edge as the commit still uses the previous increment. A staging write at the same edge as the commit is not part of the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency counting clock |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Accumulate on this edge when high |
| wrLoEn | input | 1 | Write strobe for staged increment bits [15:0] |
| wrLoData | input | 16 | Data for staged increment bits [15:0] |
| wrHiEn | input | 1 | Write strobe for staged increment bits [23:16] |
| wrHiData | input | 8 | Data for staged increment bits [23:16] |
| commit | input | 1 | Copy staged increment into the active increment |
| seconds | output | 32 | Whole-second count |
| subsec | output | 32 | Fraction of a second, 2^32 counts per second |
| activeInc | output | 24 | Increment currently in use (read only) |

## Verification
The hidden accumulator cannot be read at the ports, so its contents are exposed only through the carries they produce. The stimulus uses tiny increments such as 1 and 0x3F, stopped just short of and just past 64 steps, with a stall placed in between. A lost residue then shows up as a missing subsecond count. Exact expected values for long runs come from the product N*inc computed in 64-bit arithmetic in the bench. That exactness lets one run with an increment that is not a power of two check the long-run rate of 2^38/inc.

// File: rtl/rtc_frac_pkg.sv
package rtc_frac_pkg;

  // strobes from the control side into the counting datapath
  typedef struct packed {
    logic advance;   // accumulate on this edge
    logic loadInc;   // copy staged increment into the active one
  } ctrlStrobes_t;

endpackage

// File: rtl/rtc_inc_ctrl.sv
module rtc_inc_ctrl
  import rtc_frac_pkg::*;
#(
  parameter int IncW = 24,
  parameter int LoW  = 16,
  parameter logic [IncW-1:0] DefaultInc = 24'h800000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                countEn,
  input  logic                wrLoEn,
  input  logic [LoW-1:0]      wrLoData,
  input  logic                wrHiEn,
  input  logic [IncW-LoW-1:0] wrHiData,
  input  logic                commit,
  output ctrlStrobes_t        strobes,
  output logic [IncW-1:0]     stagedInc
);

  localparam int HiW = IncW - LoW;

  logic [LoW-1:0] stageLo;
  logic [HiW-1:0] stageHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageLo <= DefaultInc[LoW-1:0];
      stageHi <= DefaultInc[IncW-1:LoW];
    end else begin
      if (wrLoEn) stageLo <= wrLoData;
      if (wrHiEn) stageHi <= wrHiData;
    end
  end

  assign stagedInc = {stageHi, stageLo};

  always_comb begin
    strobes         = '0;
    strobes.advance = countEn & ~rst;
    strobes.loadInc = commit & ~rst;
  end

  // R7
  stage_lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrLoEn)) |-> $stable(stageLo));

  // R7
  stage_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrHiEn)) |-> $stable(stageHi));

endmodule

// File: rtl/rtc_count_dp.sv
module rtc_count_dp
  import rtc_frac_pkg::*;
#(
  parameter int IncW  = 24,
  parameter int FracW = 6,
  parameter int SubW  = 32,
  parameter int SecW  = 32,
  parameter logic [IncW-1:0] DefaultInc = 24'h800000
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrlStrobes_t    strobes,
  input  logic [IncW-1:0] stagedInc,
  output logic [SecW-1:0] seconds,
  output logic [SubW-1:0] subsec,
  output logic [IncW-1:0] activeInc
);

  localparam int CoarseW = IncW - FracW;
  localparam int SumW    = SubW + 1;

  logic            fracCarry;
  logic [SumW-1:0] subSum;
  logic            secCarry;
  logic [CoarseW-1:0] coarseInc;

  assign coarseInc = activeInc[IncW-1:FracW];

  // hidden sub-LSB accumulator, present only when the increment has fraction bits
  generate
    if (FracW > 0) begin : g_frac
      logic [FracW-1:0] fracAcc;
      logic [FracW:0]   fracSum;

      assign fracSum   = {1'b0, fracAcc} + {1'b0, activeInc[FracW-1:0]};
      assign fracCarry = fracSum[FracW];

      always_ff @(posedge clk) begin
        if (rst)                  fracAcc <= '0;
        else if (strobes.advance) fracAcc <= fracSum[FracW-1:0];
      end

      // R6
      frac_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(strobes.advance)) |-> $stable(fracAcc));
    end else begin : g_nofrac
      assign fracCarry = 1'b0;
    end
  endgenerate

  assign subSum   = {1'b0, subsec} + SumW'(coarseInc) + SumW'(fracCarry);
  assign secCarry = subSum[SubW];

  always_ff @(posedge clk) begin
    if (rst) begin
      subsec  <= '0;
      seconds <= '0;
    end else if (strobes.advance) begin
      subsec  <= subSum[SubW-1:0];
      seconds <= seconds + SecW'(secCarry);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  activeInc <= DefaultInc;
    else if (strobes.loadInc) activeInc <= stagedInc;
  end

  // R6
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.advance)) |-> ($stable(subsec) && $stable(seconds)));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (seconds != $past(seconds)))
      |-> ((seconds == $past(seconds) + SecW'(1)) && (subsec < $past(subsec))));

  // R2
  sub_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobes.advance) && (seconds == $past(seconds)))
      |-> ((subsec - $past(subsec) >= SubW'($past(coarseInc)))
        && (subsec - $past(subsec) <= SubW'($past(coarseInc)) + SubW'(1))));

  // R8
  inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobes.loadInc)) |-> $stable(activeInc));

endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter
  import rtc_frac_pkg::*;
#(
  parameter int IncW  = 24,
  parameter int FracW = 6,
  parameter int SubW  = 32,
  parameter int SecW  = 32,
  parameter int LoW   = 16,
  parameter logic [IncW-1:0] DefaultInc = 24'h800000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                countEn,
  input  logic                wrLoEn,
  input  logic [LoW-1:0]      wrLoData,
  input  logic                wrHiEn,
  input  logic [IncW-LoW-1:0] wrHiData,
  input  logic                commit,
  output logic [SecW-1:0]     seconds,
  output logic [SubW-1:0]     subsec,
  output logic [IncW-1:0]     activeInc
);

  ctrlStrobes_t    strobes;
  logic [IncW-1:0] stagedInc;

  rtc_inc_ctrl #(
    .IncW(IncW), .LoW(LoW), .DefaultInc(DefaultInc)
  ) u_ctrl (
    .clk(clk), .rst(rst), .countEn(countEn),
    .wrLoEn(wrLoEn), .wrLoData(wrLoData),
    .wrHiEn(wrHiEn), .wrHiData(wrHiData),
    .commit(commit), .strobes(strobes), .stagedInc(stagedInc)
  );

  rtc_count_dp #(
    .IncW(IncW), .FracW(FracW), .SubW(SubW), .SecW(SecW), .DefaultInc(DefaultInc)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .stagedInc(stagedInc),
    .seconds(seconds), .subsec(subsec), .activeInc(activeInc)
  );

endmodule

// File: tb/tb_rtc_frac_counter.sv
`timescale 1ns/1ps
module tb_rtc_frac_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        countEn = 1'b0;
  logic        wrLoEn = 1'b0;
  logic [15:0] wrLoData = '0;
  logic        wrHiEn = 1'b0;
  logic [7:0]  wrHiData = '0;
  logic        commit = 1'b0;
  logic [31:0] seconds;
  logic [31:0] subsec;
  logic [23:0] activeInc;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  rtc_frac_counter dut (
    .clk(clk), .rst(rst), .countEn(countEn),
    .wrLoEn(wrLoEn), .wrLoData(wrLoData),
    .wrHiEn(wrHiEn), .wrHiData(wrHiData),
    .commit(commit), .seconds(seconds), .subsec(subsec), .activeInc(activeInc)
  );

  // {increment[23:0], enabled cycles[31:0]}
  localparam int NVEC = 6;
  localparam logic [55:0] VEC [NVEC] = '{
    {24'h800000, 32'd1000},
    {24'h000001, 32'd100},
    {24'h00003F, 32'd65},
    {24'hFFFFFF, 32'd5000},
    {24'h123456, 32'd777},
    {24'hC35000, 32'd60000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; countEn = 1'b0; commit = 1'b0; wrLoEn = 1'b0; wrHiEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runCycles(input int n);
    countEn = 1'b1;
    repeat (n) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic stage(input logic [23:0] v);
    wrLoEn = 1'b1; wrLoData = v[15:0];
    wrHiEn = 1'b1; wrHiData = v[23:16];
    @(negedge clk);
    wrLoEn = 1'b0; wrHiEn = 1'b0;
  endtask

  task automatic pulseCommit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    #1_600_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] total;
    doReset();
    // R1 reset state
    check("R1 seconds", 64'(seconds), 64'd0);
    check("R1 subsec", 64'(subsec), 64'd0);
    check("R1 activeInc", 64'(activeInc), 64'h800000);

    // R4 default increment: exactly one second per 32768 cycles
    runCycles(32767);
    check("R4 seconds before 32768", 64'(seconds), 64'd0);
    runCycles(1);
    check("R4 seconds at 32768", 64'(seconds), 64'd1);
    check("R3 subsec wrapped", 64'(subsec), 64'd0);
    runCycles(32768);
    check("R4 seconds at 65536", 64'(seconds), 64'd2);

    // R5 vector table: exact count for several increments
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] inc;
      logic [31:0] n;
      inc = VEC[i][55:32];
      n   = VEC[i][31:0];
      doReset();
      stage(inc);
      pulseCommit();
      check("R8 activeInc after commit", 64'(activeInc), 64'(inc));
      runCycles(int'(n));
      total = 64'(n) * 64'(inc);
      check("R5 seconds", 64'(seconds), total >> 38);
      check("R2 R5 subsec", 64'(subsec), (total >> 6) & 64'hFFFF_FFFF);
    end

    // R6 stall keeps hidden residue: inc = 1, 40 + stall + 24 cycles
    doReset();
    stage(24'h000001);
    pulseCommit();
    runCycles(40);
    check("R2 below one LSB", 64'(subsec), 64'd0);
    repeat (10) @(negedge clk);
    check("R6 stall subsec", 64'(subsec), 64'd0);
    check("R6 stall seconds", 64'(seconds), 64'd0);
    runCycles(24);
    check("R6 residue kept across stall", 64'(subsec), 64'd1);

    // R7 staging without commit has no effect
    doReset();
    stage(24'h561234);
    check("R7 activeInc unchanged", 64'(activeInc), 64'h800000);
    runCycles(4);
    check("R7 counting uses old inc", 64'(subsec), 64'h80000);
    pulseCommit();
    check("R8 commit copies staged", 64'(activeInc), 64'h561234);

    // R8 a write at the commit edge is not part of the committed value
    wrHiEn = 1'b1; wrHiData = 8'h01; commit = 1'b1;
    @(negedge clk);
    wrHiEn = 1'b0; commit = 1'b0;
    check("R8 same-edge write excluded", 64'(activeInc), 64'h561234);
    pulseCommit();
    check("R8 later commit takes write", 64'(activeInc), 64'h011234);

    // R8 counting edge coinciding with commit uses previous increment
    doReset();
    stage(24'h000040);
    countEn = 1'b1; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    countEn = 1'b0;
    check("R8 commit edge uses old inc", 64'(subsec), 64'h20001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule